// File: doc/BRIEF.md
# Watchdog Timer with Reset Request Control

This block is an 8-bit up-counting timer that runs in one of two modes. In watchdog mode, a counter overflow records a sticky cause flag and can ask the chip for a reset. The reset can be of the power-on kind or the manual kind. Every watchdog overflow also returns the timer to its idle state. In interval mode, an overflow only raises a timer-local flag and pulses an interrupt, and the counter wraps and keeps running.

Software reaches three 8-bit registers over a simple synchronous register bus, using a select, a write strobe, a 2-bit address and a data byte. Reads are combinational from the address. The timer control register picks the mode, enables counting and selects one of eight prescaler tick rates. The counter register can be read and loaded. The reset control register holds the sticky watchdog flag, the reset enable and the reset kind. The sticky flag can be cleared only by a read that returns it as 1, followed by a write of 0.

Top module: `watchdog_rst_ctrl`

## Requirements
- R1: After reset, the timer control register reads 0x00, the counter reads 0x00 and the reset control register reads 0x1F. Its low five bits always read 1, and writes to them have no effect.
- R2: In the reset control register, bit 7 is the watchdog flag, bit 6 is the reset enable and bit 5 is the reset kind. A write can never set bit 7.
- R3: Only an overflow in watchdog mode (counter at 0xFF when a tick arrives) sets the watchdog flag. An interval-mode overflow never sets it and never requests a reset.
- R4: The watchdog flag clears only on a write with bit 7 = 0 that follows a read of the reset control register that returned bit 7 as 1. Any write to that register consumes the armed state, so a write of 0 without such a read leaves the flag set.
- R5: With the enable set, a watchdog overflow produces a one-cycle request in the cycle after the overflow edge: on `por_req` when the kind is 0, and on `mrst_req` when the kind is 1. The two requests are never high together.
- R6: Every watchdog overflow returns the counter to 0x00 and the timer control register to 0x00. When the enable is 0, neither request output rises.
- R7: A power-on request returns the reset control register to 0x1F. A manual request leaves it intact, so the flag, enable and kind stay readable.
- R8: The timer control register has its interval flag at bit 7, the mode at bit 6 (1 = watchdog), the enable at bit 5, zeros at bits 4:3 and the prescaler select at bits 2:0. Address 0 is this register, address 1 is the counter, address 2 is the reset control register, and address 3 reads 0x00.
- R9: In interval mode, an overflow sets the interval flag, pulses `ivl_irq` for one cycle, and lets the counter wrap to 0x00 and keep counting. Writing the interval flag as 0 clears it, and writing it as 1 has no effect.
- R10: With select k, the counter advances once every 2^(BASE_SHIFT+k) clock cycles while enabled. The first tick comes that many cycles after the enable edge. Clearing the enable stops counting and restarts the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read when selected |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| por_req | output | 1 | One-cycle power-on reset request |
| mrst_req | output | 1 | One-cycle manual reset request |
| ivl_irq | output | 1 | One-cycle interval overflow interrupt |

## Verification
The bench builds the block with BASE_SHIFT = 0. With that setting, select 0 ticks on every cycle and select 3 ticks every eighth cycle. Watchdog and interval overflows from a preloaded 0xF0 or 0xF8 then arrive within a few dozen cycles, and exact tick counts can be predicted for both rates. This keeps every reset kind, the disabled-reset self-clear, the blind and armed clears and the interval wrap within a short run.

// File: rtl/wdt_pkg.sv
// Shared constants for the watchdog block: register width, address map and
// bit positions that software and the bench both depend on.
package wdt_pkg;
    localparam int REG_W = 8;
    localparam int SEL_W = 3;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_TCTL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd1;
    localparam logic [ADDR_W-1:0] A_RCSR = 2'd2;

    // timer control register bit positions
    localparam int TC_IFLAG = 7;
    localparam int TC_MODE  = 6;
    localparam int TC_EN    = 5;

    // reset control register bit positions
    localparam int RC_FLAG  = 7;
    localparam int RC_ENA   = 6;
    localparam int RC_KIND  = 5;
    localparam logic [4:0] RC_RSV = 5'h1F;
endpackage

// File: rtl/wdt_prescaler.sv
// Free-running clock divider for the timer.
// Produces a one-cycle tick every 2^(BASE_SHIFT+sel) cycles while enabled.
// Assumes: the divider restarts from zero whenever the enable is low.
module wdt_prescaler #(
    parameter int BASE_SHIFT = 1,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = BASE_SHIFT + (1 << SEL_W);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // divider count, held at zero while disabled
    always_ff @(posedge clk) begin
        if (!rst_n)   pre_q <= '0;
        else if (!en) pre_q <= '0;
        else          pre_q <= pre_q + 1'b1;
    end

    // tick when the low BASE_SHIFT+sel bits are all ones
    always_comb begin
        mask = (PRE_W'(1) << (BASE_SHIFT + int'(sel))) - PRE_W'(1);
        tick = en && ((pre_q & mask) == mask);
    end
endmodule

// File: rtl/wdt_counter.sv
// Counter and timer control register.
// Detects overflow, splits it by mode, self-clears on a watchdog overflow,
// and wraps and interrupts on an interval overflow.
// Assumes: a watchdog overflow wins over a same-cycle bus write.
module wdt_counter
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_tctl,
    input  logic             wr_cnt,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] cnt_q,
    output logic [REG_W-1:0] tctl_rd,
    output logic             en_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             wdt_ovf,
    output logic             ivl_irq
);
    logic             iflag_q, mode_q, en_q;
    logic [SEL_W-1:0] sel_q;
    logic             ovf, ivl_ovf;

    // overflow detection and split by mode
    always_comb begin
        ovf     = tick && (cnt_q == {REG_W{1'b1}});
        wdt_ovf = ovf && mode_q;
        ivl_ovf = ovf && !mode_q;
    end

    // counter: self-clear, then bus load, then count
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (wdt_ovf) cnt_q <= '0;
        else if (wr_cnt)  cnt_q <= wdata;
        else if (tick)    cnt_q <= cnt_q + 1'b1;
    end

    // timer control register: self-clear, or write with a clear-only flag
    always_ff @(posedge clk) begin
        if (!rst_n || wdt_ovf) begin
            iflag_q <= 1'b0;
            mode_q  <= 1'b0;
            en_q    <= 1'b0;
            sel_q   <= '0;
        end else begin
            if (wr_tctl) begin
                mode_q <= wdata[TC_MODE];
                en_q   <= wdata[TC_EN];
                sel_q  <= wdata[SEL_W-1:0];
            end
            iflag_q <= (wr_tctl ? (iflag_q & wdata[TC_IFLAG]) : iflag_q) | ivl_ovf;
        end
    end

    // one-cycle interval interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) ivl_irq <= 1'b0;
        else        ivl_irq <= ivl_ovf;
    end

    assign tctl_rd = {iflag_q, mode_q, en_q, 2'b00, sel_q};
    assign en_o    = en_q;
    assign sel_o   = sel_q;

    AST_SELF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_ovf |=> (cnt_q == '0) && (tctl_rd == '0)); // R6
    AST_IVL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ivl_ovf && !wr_cnt) |=> (cnt_q == '0) && iflag_q); // R9
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_irq |=> !ivl_irq); // R9
endmodule

// File: rtl/wdt_rstctl.sv
// Reset control register.
// Holds the sticky watchdog flag and its read-then-write-0 clear, the reset
// enable and kind, and issues the registered one-cycle reset requests.
// Assumes: a power-on request returns this register to its initial state.
module wdt_rstctl
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wdt_ovf,
    input  logic             rd_rcsr,
    input  logic             wr_rcsr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rcsr_rd,
    output logic             por_req,
    output logic             mrst_req
);
    logic flag_q, ena_q, kind_q, armed_q;
    logic req_now, por_now, mrst_now, clr_ok;

    // request decode and the armed-clear condition
    always_comb begin
        req_now  = wdt_ovf && ena_q;
        por_now  = req_now && !kind_q;
        mrst_now = req_now && kind_q;
        clr_ok   = wr_rcsr && armed_q && !wdata[RC_FLAG];
    end

    // register fields; a power-on request restores the initial state
    always_ff @(posedge clk) begin
        if (!rst_n || por_now) begin
            flag_q <= 1'b0;
            ena_q  <= 1'b0;
            kind_q <= 1'b0;
        end else begin
            flag_q <= wdt_ovf | (flag_q & !clr_ok);
            if (wr_rcsr) begin
                ena_q  <= wdata[RC_ENA];
                kind_q <= wdata[RC_KIND];
            end
        end
    end

    // armed by a read that sees the flag set, consumed by any write
    always_ff @(posedge clk) begin
        if (!rst_n || por_now)        armed_q <= 1'b0;
        else if (wr_rcsr)             armed_q <= 1'b0;
        else if (rd_rcsr && flag_q)   armed_q <= 1'b1;
    end

    // registered one-cycle reset requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            por_req  <= 1'b0;
            mrst_req <= 1'b0;
        end else begin
            por_req  <= por_now;
            mrst_req <= mrst_now;
        end
    end

    assign rcsr_rd = {flag_q, ena_q, kind_q, RC_RSV};

    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(wdt_ovf)); // R3
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> ($past(armed_q && wr_rcsr && !wdata[RC_FLAG]) || por_req)); // R4
    AST_POR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        por_req |=> !por_req); // R5
    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(por_req && mrst_req)); // R5
    AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wdt_ovf) && !$past(ena_q)) |-> (!por_req && !mrst_req)); // R6
endmodule

// File: rtl/watchdog_rst_ctrl.sv
// Top of the watchdog timer.
// Decodes the register bus, muxes read data and joins the prescaler,
// the counter with its control register, and the reset control register.
// Assumes: reads are combinational and a read access occupies one cycle.
module watchdog_rst_ctrl
    import wdt_pkg::*;
#(
    parameter int BASE_SHIFT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              por_req,
    output logic              mrst_req,
    output logic              ivl_irq
);
    logic             wr_tctl, wr_cnt, wr_rcsr, rd_rcsr;
    logic             tick, en, wdt_ovf;
    logic [SEL_W-1:0] sel;
    logic [REG_W-1:0] cnt_q, tctl_rd, rcsr_rd;

    // bus access decode
    always_comb begin
        wr_tctl = bus_sel && bus_wr && (bus_addr == A_TCTL);
        wr_cnt  = bus_sel && bus_wr && (bus_addr == A_CNT);
        wr_rcsr = bus_sel && bus_wr && (bus_addr == A_RCSR);
        rd_rcsr = bus_sel && !bus_wr && (bus_addr == A_RCSR);
    end

    // read data mux
    always_comb begin
        case (bus_addr)
            A_TCTL:  bus_rdata = tctl_rd;
            A_CNT:   bus_rdata = cnt_q;
            A_RCSR:  bus_rdata = rcsr_rd;
            default: bus_rdata = '0;
        endcase
    end

    wdt_prescaler #(.BASE_SHIFT(BASE_SHIFT), .SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(en), .sel(sel), .tick(tick)
    );

    wdt_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_tctl(wr_tctl),
        .wr_cnt(wr_cnt), .wdata(bus_wdata), .cnt_q(cnt_q), .tctl_rd(tctl_rd),
        .en_o(en), .sel_o(sel), .wdt_ovf(wdt_ovf), .ivl_irq(ivl_irq)
    );

    wdt_rstctl u_rst (
        .clk(clk), .rst_n(rst_n), .wdt_ovf(wdt_ovf), .rd_rcsr(rd_rcsr),
        .wr_rcsr(wr_rcsr), .wdata(bus_wdata), .rcsr_rd(rcsr_rd),
        .por_req(por_req), .mrst_req(mrst_req)
    );
endmodule

// File: tb/watchdog_rst_ctrl_test.sv
`timescale 1ns/1ps
// Scoreboard bench: bus tasks push expected read data and a tag into queues.
// A negedge monitor pops and compares them, and counts request and
// interrupt pulses.
module watchdog_rst_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       por_req, mrst_req, ivl_irq;

    int checks = 0;
    int errors = 0;
    int por_cnt = 0;
    int mrst_cnt = 0;
    int irq_cnt = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    watchdog_rst_ctrl #(.BASE_SHIFT(0)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .por_req(por_req), .mrst_req(mrst_req), .ivl_irq(ivl_irq)
    );

    // monitor: compare reads against the scoreboard and count pulses
    always @(negedge clk) begin
        if (rst_n) begin
            if (por_req)  por_cnt++;
            if (mrst_req) mrst_cnt++;
            if (ivl_irq)  irq_cnt++;
            if (bus_sel && !bus_wr) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected read actual %02h expected none", bus_rdata);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (bus_rdata !== e) begin
                        errors++;
                        $display("FAIL %s actual %02h expected %02h", t, bus_rdata, e);
                    end
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic chk(input int act, input int exp, input string t);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", t, act, exp);
        end
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values; R8: address 3 reads zero
        rd(2'd0, 8'h00, "R1 timer control reset");
        rd(2'd1, 8'h00, "R1 counter reset");
        rd(2'd2, 8'h1F, "R1 reset control reset");
        rd(2'd3, 8'h00, "R8 unused address");

        // R2: flag not writable as 1, reserved bits stay 1
        wr(2'd2, 8'hFF);
        rd(2'd2, 8'h7F, "R2 write all ones");
        wr(2'd2, 8'h00);
        rd(2'd2, 8'h1F, "R1 reserved bits ignore 0");

        // R10: select 0 ticks every cycle
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h20);
        idle(8);
        wr(2'd0, 8'h00);
        rd(2'd1, 8'h0A, "R10 select 0 count");

        // R10: select 3 ticks every eighth cycle
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h23);
        rd(2'd0, 8'h23, "R8 control layout");
        idle(65);
        wr(2'd0, 8'h00);
        rd(2'd1, 8'h08, "R10 select 3 count");

        // R9 / R3: interval overflow sets local flag only
        wr(2'd1, 8'hF8);
        wr(2'd0, 8'h20);
        idle(20);
        rd(2'd0, 8'hA0, "R9 interval flag set");
        rd(2'd2, 8'h1F, "R3 no watchdog flag in interval mode");
        chk(irq_cnt, 1, "R9 interrupt pulse count");
        wr(2'd0, 8'h80);
        rd(2'd0, 8'h80, "R9 write 1 keeps flag, disables");
        wr(2'd0, 8'h00);
        rd(2'd0, 8'h00, "R9 write 0 clears flag");

        // R6: watchdog overflow with reset disabled
        wr(2'd1, 8'hF0);
        wr(2'd0, 8'h60);
        idle(40);
        rd(2'd1, 8'h00, "R6 counter self reset");
        rd(2'd0, 8'h00, "R6 control self reset");
        chk(por_cnt + mrst_cnt, 0, "R6 no request when disabled");
        rd(2'd2, 8'h9F, "R3 flag set by watchdog overflow");

        // R4: any write consumes the arm; a blind write 0 keeps the flag
        wr(2'd2, 8'h9F);
        wr(2'd2, 8'h1F);
        rd(2'd2, 8'h9F, "R4 blind write 0 keeps flag");
        wr(2'd2, 8'h1F);
        rd(2'd2, 8'h1F, "R4 armed write 0 clears flag");

        // R5 / R7: manual reset keeps the register
        wr(2'd2, 8'h60);
        rd(2'd2, 8'h7F, "R2 enable and kind fields");
        wr(2'd1, 8'hF0);
        wr(2'd0, 8'h60);
        idle(40);
        chk(mrst_cnt, 1, "R5 manual request pulse");
        chk(por_cnt, 0, "R5 no power-on request for kind 1");
        rd(2'd2, 8'hFF, "R7 manual keeps register");
        wr(2'd2, 8'h1F);
        rd(2'd2, 8'h1F, "R4 clear after manual");

        // R5 / R7: power-on reset clears the register
        wr(2'd2, 8'h40);
        wr(2'd1, 8'hF0);
        wr(2'd0, 8'h60);
        idle(40);
        chk(por_cnt, 1, "R5 power-on request pulse");
        chk(mrst_cnt, 1, "R5 no extra manual request");
        rd(2'd2, 8'h1F, "R7 power-on clears register");
        rd(2'd1, 8'h00, "R6 counter after power-on request");

        // R3: interval overflow with reset enabled requests nothing
        wr(2'd2, 8'h40);
        wr(2'd1, 8'hF8);
        wr(2'd0, 8'h20);
        idle(20);
        wr(2'd0, 8'h00);
        chk(por_cnt + mrst_cnt, 2, "R3 no request from interval overflow");
        chk(irq_cnt, 2, "R9 second interrupt");
        rd(2'd2, 8'h5F, "R3 flag stays clear in interval mode");

        idle(3);
        chk(exp_q.size(), 0, "scoreboard drained");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule